// File: doc/BRIEF.md
# Windowed Data-Memory Access Unit

This unit sits between the load/store side of a small 8-bit controller core and its data map. The core presents one address per access, with write data and a write enable, and gets back read data. Two locations in the map hold no data. Each is a window that forwards the access to the RAM location named by its own 8-bit pointer register. The pointers can be read and written like any other location.

The unit looks up each direct address, swaps in the pointer for a window, and sends the access to one target. That target is a pointer, a general-purpose RAM cell, or one of two core registers (accumulator and status) that it passes through. If a pointer names a window location, the access falls into a null sink: the read returns zero and the write has no effect.

Indirection is one level deep. Each access writes at most one storage location, so no window-to-window move is possible in one access.

Top module: `dmw_unit`

## Requirements
- R1: A synchronous reset sets both pointers to 00h. After reset, reads of addresses 01h and 03h return 00h.
- R2: Pointer A lives at 01h and pointer B at 03h. A write with `we`=1 loads `wdata` into the pointer on the rising edge, and a read returns the current pointer value.
- R3: An access to address 00h uses the value of pointer A as its address. An access to address 02h uses pointer B. Reads and writes of RAM then go to that location.
- R4: An indirect read whose pointer value is 00h or 02h returns 00h.
- R5: An indirect write whose pointer value is 00h or 02h changes no pointer and no RAM cell, and raises neither `acc_wr` nor `status_wr`.
- R6: The pointer value is used as a plain address, with no further indirection. A pointer holding 01h or 03h reaches the other pointer register itself, for both reads and writes.
- R7: RAM covers addresses RAM_BASE to RAM_BASE+RAM_DEPTH-1 (default 20h to 5Fh). Reads of addresses that map to nothing return 00h, and writes to them change nothing.
- R8: `rdata` follows `addr` and the stored state with no clock. A write commits only on a rising edge with `we`=1, and nothing changes when `we`=0.
- R9: A read of 05h returns `acc_val`, and a read of 0Ah returns `status_val`, whether the address is direct or comes from a pointer. A write to those addresses raises `acc_wr` or `status_wr` in the same cycle.
- R10: One access writes at most one target: a single pointer, one RAM cell, or a single core-register strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Direct address from the core |
| wdata | input | 8 | Write data |
| we | input | 1 | Write enable |
| rdata | output | 8 | Read data, combinational |
| acc_val | input | 8 | Current accumulator value from the core |
| status_val | input | 8 | Current status register value from the core |
| acc_wr | output | 1 | Accumulator write strobe, combinational |
| status_wr | output | 1 | Status register write strobe, combinational |

## Verification
Read data and the two write strobes are combinational. The bench therefore samples them 1 ns after it drives the inputs on the falling edge, in the same cycle and before any rising edge. A write commits on the next rising edge. Its effect is checked by a read in a later vector, never in the cycle of the write. The reset check also reads the pointers only after the rising edge that saw reset.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
    localparam int unsigned MAP_AW = 8;

    localparam logic [MAP_AW-1:0] WIN_A_ADDR  = 8'h00;
    localparam logic [MAP_AW-1:0] PTR_A_ADDR  = 8'h01;
    localparam logic [MAP_AW-1:0] WIN_B_ADDR  = 8'h02;
    localparam logic [MAP_AW-1:0] PTR_B_ADDR  = 8'h03;
    localparam logic [MAP_AW-1:0] ACC_ADDR    = 8'h05;
    localparam logic [MAP_AW-1:0] STATUS_ADDR = 8'h0A;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_NULL,
        CL_PTR_A,
        CL_PTR_B,
        CL_ACC,
        CL_STATUS,
        CL_RAM
    } dm_class_e;
endpackage

// File: rtl/dmw_ptr_regs.sv
module dmw_ptr_regs #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ptr_a,
    output logic [DW-1:0] ptr_b
);
    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_a) st_d.a = wdata;
        if (wr_b) st_d.b = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ptr_a = st_q.a;
    assign ptr_b = st_q.b;
endmodule

// File: rtl/dmw_resolve.sv
module dmw_resolve
    import dmw_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter int unsigned RAM_BASE  = 32,
    parameter int unsigned RAM_DEPTH = 64,
    localparam int unsigned IW       = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1,
    localparam int unsigned RAM_END  = RAM_BASE + RAM_DEPTH
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ptr_a,
    input  logic [AW-1:0] ptr_b,
    output dm_class_e     cls,
    output logic [IW-1:0] ram_idx
);
    logic [AW-1:0] eff_d;
    logic          indirect_d;
    logic          eff_is_win;
    logic          in_ram;

    // One level only: the pointer value is the final address.
    always_comb begin
        indirect_d = 1'b0;
        eff_d      = addr;
        if (addr == AW'(WIN_A_ADDR)) begin
            indirect_d = 1'b1;
            eff_d      = ptr_a;
        end else if (addr == AW'(WIN_B_ADDR)) begin
            indirect_d = 1'b1;
            eff_d      = ptr_b;
        end
    end

    assign eff_is_win = (eff_d == AW'(WIN_A_ADDR)) || (eff_d == AW'(WIN_B_ADDR));
    assign in_ram     = (32'(eff_d) >= RAM_BASE) && (32'(eff_d) < RAM_END);
    assign ram_idx    = IW'(32'(eff_d) - RAM_BASE);

    always_comb begin
        cls = CL_NONE;
        if (indirect_d && eff_is_win)           cls = CL_NULL;
        else if (eff_d == AW'(PTR_A_ADDR))      cls = CL_PTR_A;
        else if (eff_d == AW'(PTR_B_ADDR))      cls = CL_PTR_B;
        else if (eff_d == AW'(ACC_ADDR))        cls = CL_ACC;
        else if (eff_d == AW'(STATUS_ADDR))     cls = CL_STATUS;
        else if (in_ram)                        cls = CL_RAM;
    end
endmodule

// File: rtl/dmw_ram.sv
module dmw_ram #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) cells_q[idx] <= wdata;
    end

    assign rdata = cells_q[idx];
endmodule

// File: rtl/dmw_unit.sv
module dmw_unit
    import dmw_pkg::*;
#(
    parameter int unsigned DW        = 8,
    parameter int unsigned AW        = 8,
    parameter int unsigned RAM_BASE  = 32,
    parameter int unsigned RAM_DEPTH = 64,
    localparam int unsigned IW       = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] acc_val,
    input  logic [DW-1:0] status_val,
    output logic          acc_wr,
    output logic          status_wr
);
    dm_class_e     cls;
    logic [IW-1:0] ram_idx;
    logic [DW-1:0] ptr_a_q, ptr_b_q, ram_rd;
    logic [AW-1:0] ptr_a_addr, ptr_b_addr;
    logic          ram_we, ptr_a_we, ptr_b_we;

    assign ptr_a_addr = AW'(ptr_a_q);
    assign ptr_b_addr = AW'(ptr_b_q);

    dmw_resolve #(
        .AW(AW), .RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH)
    ) resolve_i (
        .addr(addr), .ptr_a(ptr_a_addr), .ptr_b(ptr_b_addr),
        .cls(cls), .ram_idx(ram_idx)
    );

    // Exactly one target per access: strobes decode a single class.
    always_comb begin
        ptr_a_we  = we && (cls == CL_PTR_A);
        ptr_b_we  = we && (cls == CL_PTR_B);
        ram_we    = we && (cls == CL_RAM);
        acc_wr    = we && (cls == CL_ACC);
        status_wr = we && (cls == CL_STATUS);
    end

    dmw_ptr_regs #(.DW(DW)) ptrs_i (
        .clk(clk), .rst(rst), .wr_a(ptr_a_we), .wr_b(ptr_b_we),
        .wdata(wdata), .ptr_a(ptr_a_q), .ptr_b(ptr_b_q)
    );

    dmw_ram #(.DW(DW), .DEPTH(RAM_DEPTH)) ram_i (
        .clk(clk), .wr(ram_we), .idx(ram_idx), .wdata(wdata), .rdata(ram_rd)
    );

    always_comb begin
        unique case (cls)
            CL_PTR_A:  rdata = ptr_a_q;
            CL_PTR_B:  rdata = ptr_b_q;
            CL_ACC:    rdata = acc_val;
            CL_STATUS: rdata = status_val;
            CL_RAM:    rdata = ram_rd;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmw_checker.sv
module dmw_checker
    import dmw_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          we,
    input logic [DW-1:0] rdata,
    input dm_class_e     cls,
    input logic [DW-1:0] ptr_a,
    input logic [DW-1:0] ptr_b,
    input logic          ram_we,
    input logic          ptr_a_we,
    input logic          ptr_b_we,
    input logic          acc_wr,
    input logic          status_wr
);
    p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == AW'(PTR_A_ADDR)) |=> (ptr_a == $past(wdata)));

    p_null_read_r4: assert property (@(posedge clk) disable iff (rst)
        (cls == CL_NULL) |-> (rdata == '0));

    p_null_write_r5: assert property (@(posedge clk) disable iff (rst)
        (we && cls == CL_NULL) |=> ($stable(ptr_a) && $stable(ptr_b)));

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (cls == CL_NONE) |-> (rdata == '0));

    p_hold_no_we_r8: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(ptr_a) && $stable(ptr_b)));

    p_one_target_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_we, ptr_a_we, ptr_b_we, acc_wr, status_wr}));
endmodule

bind dmw_unit dmw_checker #(.DW(DW), .AW(AW)) chk_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .cls(cls), .ptr_a(ptr_a_q), .ptr_b(ptr_b_q), .ram_we(ram_we),
    .ptr_a_we(ptr_a_we), .ptr_b_we(ptr_b_we), .acc_wr(acc_wr),
    .status_wr(status_wr)
);

// File: tb/dmw_unit_tb.sv
module dmw_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr, wdata, rdata;
    logic       we, acc_wr, status_wr;
    logic [7:0] acc_val    = 8'hA5;
    logic [7:0] status_val = 8'h3C;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    dmw_unit dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .acc_val(acc_val), .status_val(status_val),
        .acc_wr(acc_wr), .status_wr(status_wr)
    );

    // {check, we, addr, wdata, expected, tag}
    localparam int NV = 31;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h01, 8'h00, 8'h00, 4'd1},  // R1 ptr A zero
        {1'b1, 1'b0, 8'h03, 8'h00, 8'h00, 4'd1},  // R1 ptr B zero
        {1'b0, 1'b1, 8'h01, 8'h20, 8'h00, 4'd2},  // R2 ptr A = 20
        {1'b1, 1'b0, 8'h01, 8'h00, 8'h20, 4'd2},  // R2
        {1'b0, 1'b1, 8'h03, 8'h5F, 8'h00, 4'd2},  // R2 ptr B = 5F
        {1'b1, 1'b0, 8'h03, 8'h00, 8'h5F, 4'd2},  // R2
        {1'b0, 1'b1, 8'h00, 8'h11, 8'h00, 4'd3},  // R3 RAM[20]=11
        {1'b0, 1'b1, 8'h02, 8'h22, 8'h00, 4'd3},  // R3 RAM[5F]=22
        {1'b1, 1'b0, 8'h20, 8'h00, 8'h11, 4'd3},  // R3
        {1'b1, 1'b0, 8'h5F, 8'h00, 8'h22, 4'd3},  // R3
        {1'b1, 1'b0, 8'h00, 8'h00, 8'h11, 4'd3},  // R3
        {1'b1, 1'b0, 8'h02, 8'h00, 8'h22, 4'd3},  // R3
        {1'b0, 1'b1, 8'h01, 8'h02, 8'h00, 4'd4},  // R4 ptr A -> window B
        {1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 4'd4},  // R4 null read
        {1'b0, 1'b1, 8'h00, 8'h77, 8'h00, 4'd5},  // R5 null write
        {1'b1, 1'b0, 8'h01, 8'h00, 8'h02, 4'd5},  // R5 ptr A kept
        {1'b1, 1'b0, 8'h03, 8'h00, 8'h5F, 4'd5},  // R5 ptr B kept
        {1'b1, 1'b0, 8'h5F, 8'h00, 8'h22, 4'd5},  // R5 RAM kept
        {1'b0, 1'b1, 8'h03, 8'h01, 8'h00, 4'd6},  // R6 ptr B -> ptr A
        {1'b1, 1'b0, 8'h02, 8'h00, 8'h02, 4'd6},  // R6 reads ptr A itself
        {1'b0, 1'b1, 8'h02, 8'h21, 8'h00, 4'd6},  // R6 writes ptr A
        {1'b1, 1'b0, 8'h01, 8'h00, 8'h21, 4'd6},  // R6
        {1'b0, 1'b1, 8'h21, 8'h9C, 8'h00, 4'd7},  // R7 RAM[21]=9C
        {1'b1, 1'b0, 8'h00, 8'h00, 8'h9C, 4'd6},  // R6 one level via ptr A
        {1'b1, 1'b0, 8'h05, 8'h00, 8'hA5, 4'd9},  // R9 acc
        {1'b1, 1'b0, 8'h0A, 8'h00, 8'h3C, 4'd9},  // R9 status
        {1'b0, 1'b1, 8'h60, 8'h44, 8'h00, 4'd7},  // R7 beyond RAM
        {1'b1, 1'b0, 8'h60, 8'h00, 8'h00, 4'd7},  // R7
        {1'b1, 1'b0, 8'h1F, 8'h00, 8'h00, 4'd7},  // R7 below RAM
        {1'b1, 1'b0, 8'h5F, 8'h00, 8'h22, 4'd7},  // R7 top cell
        {1'b1, 1'b0, 8'h04, 8'h00, 8'h00, 4'd7}   // R7 hole in map
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        we = w; addr = a; wdata = d;
        #1;
    endtask

    initial begin
        rst = 1'b1; we = 1'b0; addr = 8'h00; wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][28], VEC[i][27:20], VEC[i][19:12]);
            if (VEC[i][29])
                check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rdata, VEC[i][11:4]);
        end

        // R8: we low leaves ptr A (21) untouched
        drive(1'b0, 8'h01, 8'hFF);
        drive(1'b0, 8'h01, 8'h00);
        check("R8 no write without we", rdata, 8'h21);
        // R8: read follows addr within the cycle
        drive(1'b0, 8'h05, 8'h00);
        acc_val = 8'h5A; #1;
        check("R8 combinational read", rdata, 8'h5A);

        // R9 / R10 strobes
        drive(1'b1, 8'h05, 8'h10);
        check("R9 acc_wr direct", {6'd0, acc_wr, status_wr}, 8'h02);
        drive(1'b1, 8'h0A, 8'h10);
        check("R9 status_wr direct", {6'd0, acc_wr, status_wr}, 8'h01);
        drive(1'b1, 8'h03, 8'h0A);          // ptr B = 0A
        drive(1'b1, 8'h02, 8'h10);
        check("R9 status_wr indirect", {6'd0, acc_wr, status_wr}, 8'h01);
        drive(1'b1, 8'h03, 8'h00);          // ptr B = 00
        drive(1'b1, 8'h02, 8'h10);
        check("R5 no strobe on null write", {6'd0, acc_wr, status_wr}, 8'h00);
        drive(1'b0, 8'h02, 8'h00);
        check("R4 null read via ptr B", rdata, 8'h00);
        drive(1'b0, 8'h03, 8'h00);
        check("R10 ptr B after null write", rdata, 8'h00);

        // R1: reset mid-run
        drive(1'b0, 8'h01, 8'h00);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0; #1;
        check("R1 ptr A after reset", rdata, 8'h00);
        drive(1'b0, 8'h03, 8'h00);
        check("R1 ptr B after reset", rdata, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule